// File: doc/BRIEF.md
# Multiplexed-Address DRAM Access Sequencer

This block turns a single host request carrying a full word address into the timed strobe sequence of a memory whose address pins carry the row half and the column half at different times. On acceptance it latches both halves of the address and the read/write select. It then drives the row half onto the shared pins, lowers the active-low row strobe, and waits out the row-to-column delay. Next it switches the pins to the column half and lowers the active-low column strobe. Finally it raises both strobes together and holds off the next access for a precharge interval.

Every phase length is a parameter counted in clock cycles. Each strobe falls only after its address half has sat on the pins for at least one setup interval. The host sees a `ready` level, which is high only when the block is idle, and a one-cycle `done` pulse. A parameter chooses whether the row half comes from the upper or the lower part of the host address. The pin group is as wide as the wider of the two halves, and the narrower half is zero-extended onto it.

Top module: `dram_addr_seq`

## Requirements
- R1: While reset is held and in the first cycle after it, `ready_o` is 1, `done_o` is 0, and `ras_n_o`, `cas_n_o` and `we_n_o` are all 1.
- R2: A request seen on a clock edge while `ready_o` is 1 is accepted. `ready_o` is 0 from the next cycle. The address and `wr_i` are latched on that edge. With `ROW_UPPER`=1 the row half is `addr_i[ADDR_W-1 -: ROW_W]` and the column half is `addr_i[COL_W-1:0]`. With `ROW_UPPER`=0 the row half is `addr_i[ROW_W-1:0]` and the column half is the upper `COL_W` bits.
- R3: For the first `T_ASU` cycles after acceptance, the pins carry the row half and both strobes are 1. For the next `T_RCD` cycles, `ras_n_o` is 0, `cas_n_o` is 1 and the pins still carry the row half.
- R4: For the next `T_ASU` cycles, the pins carry the zero-extended column half, `ras_n_o` is 0 and `cas_n_o` is 1. For the following `T_CAS` cycles, both strobes are 0 and the pins keep the column half.
- R5: Both strobes then return to 1 in the same cycle, and `done_o` is 1 for that one cycle only. `ready_o` stays 0 for `T_PRE` cycles in total and then returns to 1.
- R6: `cas_n_o` is never 0 while `ras_n_o` is 1.
- R7: The shared pins do not change in the cycle in which either strobe falls.
- R8: `we_n_o` equals the inverse of the latched `wr_i` from the cycle after acceptance through the last precharge cycle. It is 1 whenever `ready_o` is 1.
- R9: A request, address or `wr_i` change presented while `ready_o` is 0 has no effect. The pins, `we_n_o` and the sequence length stay those of the access in progress.
- R10: A request held high across the end of an access is accepted in the first cycle `ready_o` is 1, so the next sequence begins on the cycle after it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_i | input | 1 | Access request, sampled while ready |
| addr_i | input | ROW_W+COL_W | Full word address |
| wr_i | input | 1 | 1 for write, 0 for read |
| ready_o | output | 1 | High only when idle |
| done_o | output | 1 | One-cycle pulse when both strobes return high |
| ma_o | output | max(ROW_W,COL_W) | Shared row/column address pins |
| ras_n_o | output | 1 | Active-low row strobe |
| cas_n_o | output | 1 | Active-low column strobe |
| we_n_o | output | 1 | Active-low write enable, held for the whole access |

## Verification
The main instance uses an 8-bit row and a 6-bit column with phase lengths of 2, 3, 2 and 2 cycles. Because the halves are unequal, the zero-extension of the column half becomes visible on the pins. Because the phases are longer than one cycle, a miscount in any single phase changes the cycle in which a pin or strobe moves. A second instance uses 4-bit halves, the lower-half row split and every phase one cycle long, which exercises the minimum timing and the other generate branch.

// File: rtl/dram_seq_pkg.sv
package dram_seq_pkg;

   typedef enum logic [2:0] {
      ST_IDLE      = 3'd0,
      ST_ROW_SETUP = 3'd1,
      ST_RAS_ACT   = 3'd2,
      ST_COL_SETUP = 3'd3,
      ST_CAS_ACT   = 3'd4,
      ST_PRECHG    = 3'd5
   } seq_state_e;

   function automatic int unsigned max_of4(input int unsigned a, b, c, d);
      int unsigned m;
      m = a;
      if (b > m) m = b;
      if (c > m) m = c;
      if (d > m) m = d;
      return m;
   endfunction

endpackage

// File: rtl/seq_timer.sv
module seq_timer #(
   parameter int unsigned CNT_W = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic [CNT_W-1:0] load_val,
   output logic             expired
);
   logic [CNT_W-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)              cnt_q <= '0;
      else if (load)           cnt_q <= load_val;
      else if (cnt_q != '0)    cnt_q <= cnt_q - 1'b1;
   end

   assign expired = (cnt_q == '0);

   // A running count never wraps back up without a load.
   assert_no_wrap_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (!load && $past(cnt_q) != '0 && !$past(load)) |-> (cnt_q < $past(cnt_q)));
endmodule

// File: rtl/addr_hold.sv
module addr_hold #(
   parameter int unsigned ROW_W     = 8,
   parameter int unsigned COL_W     = 8,
   parameter bit          ROW_UPPER = 1'b1,
   parameter int unsigned PIN_W     = 8
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     capture,
   input  logic [ROW_W+COL_W-1:0]   addr_i,
   input  logic                     wr_i,
   input  logic                     sel_col,
   output logic [PIN_W-1:0]         ma_o,
   output logic                     wr_q
);
   localparam int unsigned ADDR_W = ROW_W + COL_W;

   logic [ROW_W-1:0] row_next, row_q;
   logic [COL_W-1:0] col_next, col_q;

   generate
      if (ROW_UPPER) begin : g_row_hi
         assign row_next = addr_i[ADDR_W-1 -: ROW_W];
         assign col_next = addr_i[COL_W-1:0];
      end else begin : g_row_lo
         assign row_next = addr_i[ROW_W-1:0];
         assign col_next = addr_i[ADDR_W-1 -: COL_W];
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         row_q <= '0;
         col_q <= '0;
         wr_q  <= 1'b0;
      end else if (capture) begin
         row_q <= row_next;
         col_q <= col_next;
         wr_q  <= wr_i;
      end
   end

   assign ma_o = sel_col ? PIN_W'(col_q) : PIN_W'(row_q);

   // Latched halves only move on a capture.
   assert_hold_stable_R9: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(capture) |-> ($stable(row_q) && $stable(col_q) && $stable(wr_q)));
endmodule

// File: rtl/seq_fsm.sv
module seq_fsm
   import dram_seq_pkg::*;
#(
   parameter int unsigned T_ASU = 1,
   parameter int unsigned T_RCD = 2,
   parameter int unsigned T_CAS = 2,
   parameter int unsigned T_PRE = 2,
   parameter int unsigned CNT_W = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             req_i,
   input  logic             expired,
   output seq_state_e       state_q,
   output logic             load,
   output logic [CNT_W-1:0] load_val,
   output logic             capture,
   output logic             done_q
);
   localparam logic [CNT_W-1:0] L_ASU = CNT_W'(T_ASU - 1);
   localparam logic [CNT_W-1:0] L_RCD = CNT_W'(T_RCD - 1);
   localparam logic [CNT_W-1:0] L_CAS = CNT_W'(T_CAS - 1);
   localparam logic [CNT_W-1:0] L_PRE = CNT_W'(T_PRE - 1);

   seq_state_e state_d;

   always_comb begin
      state_d  = state_q;
      load     = 1'b0;
      load_val = '0;
      capture  = 1'b0;
      unique case (state_q)
         ST_IDLE: if (req_i) begin
            state_d = ST_ROW_SETUP; load = 1'b1; load_val = L_ASU; capture = 1'b1;
         end
         ST_ROW_SETUP: if (expired) begin
            state_d = ST_RAS_ACT; load = 1'b1; load_val = L_RCD;
         end
         ST_RAS_ACT: if (expired) begin
            state_d = ST_COL_SETUP; load = 1'b1; load_val = L_ASU;
         end
         ST_COL_SETUP: if (expired) begin
            state_d = ST_CAS_ACT; load = 1'b1; load_val = L_CAS;
         end
         ST_CAS_ACT: if (expired) begin
            state_d = ST_PRECHG; load = 1'b1; load_val = L_PRE;
         end
         ST_PRECHG: if (expired) state_d = ST_IDLE;
         default: state_d = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         done_q  <= 1'b0;
      end else begin
         state_q <= state_d;
         done_q  <= (state_q == ST_CAS_ACT) && expired;
      end
   end

   // Phases advance only in the fixed order.
   assert_order_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q != $past(state_q)) |->
         (state_q == ST_IDLE ? $past(state_q) == ST_PRECHG
                             : $past(state_q) == seq_state_e'(state_q - 3'd1)));
   assert_accept_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_ROW_SETUP && $past(state_q) != ST_ROW_SETUP) |-> $past(req_i));
endmodule

// File: rtl/dram_addr_seq.sv
module dram_addr_seq
   import dram_seq_pkg::*;
#(
   parameter int unsigned ROW_W     = 8,
   parameter int unsigned COL_W     = 8,
   parameter bit          ROW_UPPER = 1'b1,
   parameter int unsigned T_ASU     = 1,
   parameter int unsigned T_RCD     = 2,
   parameter int unsigned T_CAS     = 2,
   parameter int unsigned T_PRE     = 2,
   localparam int unsigned ADDR_W   = ROW_W + COL_W,
   localparam int unsigned PIN_W    = (ROW_W > COL_W) ? ROW_W : COL_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_i,
   input  logic [ADDR_W-1:0] addr_i,
   input  logic              wr_i,
   output logic              ready_o,
   output logic              done_o,
   output logic [PIN_W-1:0]  ma_o,
   output logic              ras_n_o,
   output logic              cas_n_o,
   output logic              we_n_o
);
   localparam int unsigned T_MAX = max_of4(T_ASU, T_RCD, T_CAS, T_PRE);
   localparam int unsigned CNT_W = (T_MAX < 2) ? 1 : $clog2(T_MAX);

   generate
      if (T_ASU < 1 || T_RCD < 1 || T_CAS < 1 || T_PRE < 1) begin : g_bad_timing
         $error("every phase length must be at least one cycle");
      end
      if (ROW_W < 1 || COL_W < 1) begin : g_bad_width
         $error("row and column halves need at least one bit");
      end
   endgenerate

   seq_state_e       state_q;
   logic             load, capture, expired, done_q, wr_q, sel_col;
   logic [CNT_W-1:0] load_val;

   seq_fsm #(.T_ASU(T_ASU), .T_RCD(T_RCD), .T_CAS(T_CAS), .T_PRE(T_PRE),
             .CNT_W(CNT_W)) u_fsm (
      .clk(clk), .rst_n(rst_n), .req_i(req_i), .expired(expired),
      .state_q(state_q), .load(load), .load_val(load_val),
      .capture(capture), .done_q(done_q));

   seq_timer #(.CNT_W(CNT_W)) u_timer (
      .clk(clk), .rst_n(rst_n), .load(load), .load_val(load_val),
      .expired(expired));

   addr_hold #(.ROW_W(ROW_W), .COL_W(COL_W), .ROW_UPPER(ROW_UPPER),
               .PIN_W(PIN_W)) u_addr (
      .clk(clk), .rst_n(rst_n), .capture(capture), .addr_i(addr_i),
      .wr_i(wr_i), .sel_col(sel_col), .ma_o(ma_o), .wr_q(wr_q));

   assign sel_col = (state_q == ST_COL_SETUP) || (state_q == ST_CAS_ACT);
   assign ready_o = (state_q == ST_IDLE);
   assign ras_n_o = !((state_q == ST_RAS_ACT) || sel_col);
   assign cas_n_o = (state_q != ST_CAS_ACT);
   assign we_n_o  = ready_o | ~wr_q;
   assign done_o  = done_q;

   assert_cas_inside_ras_R6: assert property (@(posedge clk) disable iff (!rst_n)
      !cas_n_o |-> !ras_n_o);
   assert_ras_fall_stable_R7: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(ras_n_o) |-> $stable(ma_o));
   assert_cas_fall_stable_R7: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(cas_n_o) |-> $stable(ma_o));
   assert_strobes_rise_together_R5: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(cas_n_o) |-> ($rose(ras_n_o) && done_o));
   assert_done_pulse_R5: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |=> !done_o);
   assert_we_held_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (!ready_o && $past(!ready_o)) |-> $stable(we_n_o));
   assert_idle_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
      ready_o |-> (we_n_o && ras_n_o && cas_n_o));
   assert_accept_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (ready_o && req_i) |=> !ready_o);
endmodule

// File: tb/tb_dram_addr_seq.sv
module tb_dram_addr_seq;
   localparam int RW = 8, CW = 6, A = 2, R = 3, C = 2, P = 2;
   localparam int BUSY = 2*A + R + C + P;
   localparam int AW = RW + CW;

   logic clk = 1'b0, rst_n = 1'b0;
   logic req = 1'b0, wr = 1'b0;
   logic [AW-1:0] addr = '0;
   logic ready, done, ras_n, cas_n, we_n;
   logic [7:0] ma;

   logic req_lo = 1'b0, wr_lo = 1'b0;
   logic [7:0] addr_lo = '0;
   logic ready_lo, done_lo, ras_lo, cas_lo, we_lo;
   logic [3:0] ma_lo;

   int nchecks = 0, nfail = 0;

   always #4 clk = ~clk;

   dram_addr_seq #(.ROW_W(RW), .COL_W(CW), .ROW_UPPER(1'b1), .T_ASU(A),
                   .T_RCD(R), .T_CAS(C), .T_PRE(P)) dut (
      .clk(clk), .rst_n(rst_n), .req_i(req), .addr_i(addr), .wr_i(wr),
      .ready_o(ready), .done_o(done), .ma_o(ma), .ras_n_o(ras_n),
      .cas_n_o(cas_n), .we_n_o(we_n));

   dram_addr_seq #(.ROW_W(4), .COL_W(4), .ROW_UPPER(1'b0), .T_ASU(1),
                   .T_RCD(1), .T_CAS(1), .T_PRE(1)) dut_lo (
      .clk(clk), .rst_n(rst_n), .req_i(req_lo), .addr_i(addr_lo), .wr_i(wr_lo),
      .ready_o(ready_lo), .done_o(done_lo), .ma_o(ma_lo), .ras_n_o(ras_lo),
      .cas_n_o(cas_lo), .we_n_o(we_lo));

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      nchecks++;
      if (!ok) begin
         nfail++;
         $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
      end
   endtask

   // Drive one request from a falling edge; returns at the first busy cycle.
   task automatic start(input logic [AW-1:0] a, input logic w);
      req = 1'b1; addr = a; wr = w;
      @(negedge clk);
      req = 1'b0;
   endtask

   // Checks every busy cycle and the first ready cycle that follows.
   task automatic check_seq(input logic [AW-1:0] a, input logic w,
                            input bit poke, input bit chain,
                            input logic [AW-1:0] a2, input logic w2);
      logic [7:0] er, ec;
      er = a[AW-1 -: RW];
      ec = {2'b00, a[CW-1:0]};
      for (int i = 0; i < BUSY; i++) begin
         logic [4:0] exp;
         string tag;
         logic [7:0] em;
         bit chk_ma;
         chk_ma = 1'b1; em = er;
         if (i < A)              begin exp = 5'b0_11_0_0; tag = "R3"; end
         else if (i < A+R)       begin exp = 5'b0_01_0_0; tag = "R3"; end
         else if (i < 2*A+R)     begin exp = 5'b0_01_0_0; tag = "R4"; em = ec; end
         else if (i < 2*A+R+C)   begin exp = 5'b0_00_0_0; tag = "R4"; em = ec; end
         else begin
            exp = {1'b0, 2'b11, 1'b0, (i == 2*A+R+C)}; tag = "R5"; chk_ma = 1'b0;
         end
         exp[1] = ~w;
         chk({ready, ras_n, cas_n, we_n, done} == exp,
             poke ? "R9 strobes" : {tag, " strobes"}, {ready, ras_n, cas_n, we_n, done}, exp);
         chk(we_n == ~w, "R8 we_n", we_n, ~w);
         if (chk_ma) chk(ma == em, poke ? "R9 pins" : {tag, " pins"}, ma, em);
         if (poke && i == 2) begin req = 1'b1; addr = ~a; wr = ~w; end
         if (poke && i == 4) req = 1'b0;
         if (chain && i == BUSY-1) begin req = 1'b1; addr = a2; wr = w2; end
         @(negedge clk);
      end
      chk(ready == 1'b1, chain ? "R10 ready" : "R5 ready", ready, 1);
      chk({ras_n, cas_n, we_n, done} == 4'b1110, "R8 idle outputs",
          {ras_n, cas_n, we_n, done}, 4'b1110);
   endtask

   task automatic t_reset;
      chk({ready, done, ras_n, cas_n, we_n} == 5'b10111, "R1 in reset",
          {ready, done, ras_n, cas_n, we_n}, 5'b10111);
      rst_n = 1'b1;
      @(negedge clk);
      chk({ready, done, ras_n, cas_n, we_n} == 5'b10111, "R1 after reset",
          {ready, done, ras_n, cas_n, we_n}, 5'b10111);
   endtask

   task automatic t_read;
      start(14'h2A5C, 1'b0);
      chk(ready == 1'b0, "R2 accept", ready, 0);
      check_seq(14'h2A5C, 1'b0, 1'b0, 1'b0, '0, 1'b0);
   endtask

   task automatic t_write;
      start(14'h3FFF, 1'b1);
      check_seq(14'h3FFF, 1'b1, 1'b0, 1'b0, '0, 1'b0);
      start(14'h0040, 1'b1);
      check_seq(14'h0040, 1'b1, 1'b0, 1'b0, '0, 1'b0);
   endtask

   task automatic t_busy_ignored;
      start(14'h1235, 1'b1);
      check_seq(14'h1235, 1'b1, 1'b1, 1'b0, '0, 1'b0);
   endtask

   task automatic t_back2back;
      start(14'h0ABC, 1'b0);
      check_seq(14'h0ABC, 1'b0, 1'b0, 1'b1, 14'h3143, 1'b1);
      @(negedge clk);
      req = 1'b0;
      chk(ready == 1'b0, "R10 next accepted", ready, 0);
      check_seq(14'h3143, 1'b1, 1'b0, 1'b0, '0, 1'b0);
   endtask

   task automatic t_row_low;
      req_lo = 1'b1; addr_lo = 8'hA3; wr_lo = 1'b1;
      @(negedge clk);
      req_lo = 1'b0;
      chk(ma_lo == 4'h3 && ras_lo && cas_lo, "R2 low row setup", {ras_lo, cas_lo, ma_lo}, 6'h33);
      @(negedge clk);
      chk(ma_lo == 4'h3 && !ras_lo, "R3 low ras", {ras_lo, ma_lo}, 5'h03);
      @(negedge clk);
      chk(ma_lo == 4'hA && !ras_lo && cas_lo, "R4 low col", {ras_lo, cas_lo, ma_lo}, 6'h1A);
      @(negedge clk);
      chk(!cas_lo && !we_lo, "R4 low cas", {cas_lo, we_lo}, 0);
      @(negedge clk);
      chk(done_lo && ras_lo && cas_lo && !ready_lo, "R5 low done",
          {done_lo, ras_lo, cas_lo, ready_lo}, 4'b1110);
      @(negedge clk);
      chk(ready_lo && !done_lo && we_lo, "R5 low ready", {ready_lo, done_lo, we_lo}, 3'b101);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      t_reset();
      t_read();
      t_write();
      t_busy_ignored();
      t_back2back();
      t_row_low();
      @(negedge clk);
      $display("TB_RESULT checks=%0d failures=%0d", nchecks, nfail);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      nchecks++;
      nfail++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", nchecks, nfail);
      $finish;
   end
endmodule